// File: doc/BRIEF.md
# UART Interrupt Enable and Identification Unit

This unit is the interrupt part of a 16550-style UART register file. The host writes an 8-bit interrupt enable register over a simple register bus. That register can be reached only while the divisor-latch access input is low. The receiver, transmitter and modem logic each provide status levels. The unit gates each of these with its enable bit and ranks the active sources into four levels. It then holds the winner in an identification register, together with a pending flag, and drives an interrupt line.

One enable bit acts as a master switch for the whole unit. A separate enable controls the receiver-timeout source, which is reported at the same level as received data. How received data is detected depends on FIFO mode: a trigger-level flag is used in FIFO mode and a buffer-full flag otherwise. A read of the identification register that reports a transmitter-empty interrupt acknowledges that interrupt. The interrupt is armed again when the transmitter next becomes empty or when the transmit register is written.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0, the identification register reads 0x01 and `irq` is low.
- R2: A write to address 1 loads the enable register only while `dlab` is 0. A read of address 1 returns it only while `dlab` is 0; with `dlab` at 1 the read returns 0 and a write leaves the register unchanged. Bits 5 and 7 always read 0, and bits 31:8 of every read are 0.
- R3: Enable bits are: bit 0 data available, bit 1 transmit empty, bit 2 line status, bit 3 modem, bit 4 receiver timeout, bit 6 unit enable. While bit 6 is 0, the identification register reads 0x01 and `irq` stays low, whatever the status inputs are.
- R4: Line status (`rx_err` with bit 2) has the top priority and reads as code 011 in identification bits 3:1.
- R5: Data available (bit 0) is second and reads as code 010. It is raised by `rx_trig` when `fifo_mode` is 1 and by `rx_ready` when `fifo_mode` is 0.
- R6: Receiver timeout (`rx_timeout` with bit 4) shares the second level and reads as code 110. When data available is active at the same time, data available is reported.
- R7: Transmit empty (`tx_empty` with bit 1) is third and reads as code 001.
- R8: Modem status (`modem_chg` with bit 3) is lowest and reads as code 000.
- R9: A read of the identification register (address 2) that shows 0x02 suppresses the transmit-empty source. The suppression is lifted by a rising edge of `tx_empty` or by a `tx_write` pulse.
- R10: `irq` is high exactly when an enabled source is active and the unit is enabled. It changes one clock after the status inputs change.
- R11: Identification bit 0 is 0 while an interrupt is pending and 1 otherwise. Bits 7:4 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dlab | input | 1 | Divisor-latch access bit from the line control register |
| bus_addr | input | 2 | Register address: 1 = enable, 2 = identification |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (identification read acknowledge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| rx_err | input | 1 | One or more receive error bits set |
| fifo_mode | input | 1 | FIFO mode selected |
| rx_trig | input | 1 | Receive FIFO at its trigger level |
| rx_ready | input | 1 | Receive buffer holds a character |
| rx_timeout | input | 1 | Receive character timeout |
| tx_empty | input | 1 | Transmit holding register empty |
| tx_write | input | 1 | Transmit register written this cycle |
| modem_chg | input | 1 | Modem status change |
| irq | output | 1 | Registered interrupt line |
| ident | output | 8 | Identification register contents |

## Verification
The bench first turns on every source together and then removes them one at a time from the top. The identification code at each step shows that the ranking is strict and not a simple OR. Data available is driven in both FIFO modes, with the trigger-level and buffer-full flags set against each other, so a swapped mode select shows up. The bench drives timeout alone, then together with data available, then with its enable cleared, which places timeout at its level and under its own enable. It reads the identification register, then re-arms through a transmit write and through a new empty edge, which shows the acknowledge and both re-arm paths. Writes and reads with the latch-access bit set, and a sample taken just before the clock edge, confirm the access gating and the one-cycle delay.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 5;
  // source index = priority rank (0 highest)
  localparam int S_LS = 0;
  localparam int S_DA = 1;
  localparam int S_TO = 2;
  localparam int S_TX = 3;
  localparam int S_MS = 4;
  localparam int UNIT_BIT = 6;
  localparam logic [7:0] EN_MASK = 8'h5F;

  localparam logic [2:0] C_LS = 3'b011;
  localparam logic [2:0] C_DA = 3'b010;
  localparam logic [2:0] C_TO = 3'b110;
  localparam logic [2:0] C_TX = 3'b001;
  localparam logic [2:0] C_MS = 3'b000;

  // enable-register bit that gates each source
  function automatic int en_bit(int idx);
    case (idx)
      S_LS:    return 2;
      S_DA:    return 0;
      S_TO:    return 4;
      S_TX:    return 1;
      default: return 3;
    endcase
  endfunction

  function automatic logic [2:0] src_code(int idx);
    case (idx)
      S_LS:    return C_LS;
      S_DA:    return C_DA;
      S_TO:    return C_TO;
      S_TX:    return C_TX;
      default: return C_MS;
    endcase
  endfunction

  // index of highest-priority active source, NSRC when none
  function automatic int first_set(logic [NSRC-1:0] v);
    int r;
    r = NSRC;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  function automatic logic [7:0] pack_ident(logic pend, logic [2:0] code);
    return {4'b0000, code, ~pend};
  endfunction
endpackage

// File: rtl/uart_irq_enreg.sv
module uart_irq_enreg #(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] EN_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dlab,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [7:0]        wdata,
  output logic [7:0]        en_q,
  output logic              wr_hit
);
  import uart_irq_pkg::*;

  assign wr_hit = wr && (addr == EN_ADDR) && !dlab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 8'h00;
    else if (wr_hit) en_q <= wdata & EN_MASK;
  end
endmodule

// File: rtl/uart_irq_srcs.sv
module uart_irq_srcs (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [7:0]                   en,
  input  logic                         rx_err,
  input  logic                         fifo_mode,
  input  logic                         rx_trig,
  input  logic                         rx_ready,
  input  logic                         rx_timeout,
  input  logic                         tx_empty,
  input  logic                         tx_write,
  input  logic                         modem_chg,
  input  logic                         tx_ack,
  output logic [uart_irq_pkg::NSRC-1:0] act,
  output logic                         tx_rise
);
  import uart_irq_pkg::*;

  logic             tx_empty_q;
  logic             thr_ack_q;
  logic             thr_ack_d;
  logic [NSRC-1:0]  raw;

  assign tx_rise = tx_empty && !tx_empty_q;

  // re-arm wins over acknowledge
  always_comb begin
    thr_ack_d = thr_ack_q;
    if (tx_ack)              thr_ack_d = 1'b1;
    if (tx_rise || tx_write) thr_ack_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty_q <= 1'b0;
      thr_ack_q  <= 1'b0;
    end else begin
      tx_empty_q <= tx_empty;
      thr_ack_q  <= thr_ack_d;
    end
  end

  always_comb begin
    raw       = '0;
    raw[S_LS] = rx_err;
    raw[S_DA] = fifo_mode ? rx_trig : rx_ready;
    raw[S_TO] = rx_timeout;
    raw[S_TX] = tx_empty && !thr_ack_d;
    raw[S_MS] = modem_chg;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    localparam int B = en_bit(g);
    assign act[g] = raw[g] && en[B];
  end
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          unit_en,
  input  logic [uart_irq_pkg::NSRC-1:0] act,
  output logic                          irq,
  output logic [7:0]                    ident
);
  import uart_irq_pkg::*;

  int         win;
  logic       pend;
  logic [2:0] code;

  always_comb begin
    win  = first_set(act);
    pend = unit_en && (win < NSRC);
    code = pend ? src_code(win) : C_MS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq   <= 1'b0;
      ident <= pack_ident(1'b0, C_MS);
    end else begin
      irq   <= pend;
      ident <= pack_ident(pend, code);
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] EN_ADDR = 1,
  parameter logic [ADDR_W-1:0] ID_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dlab,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_err,
  input  logic              fifo_mode,
  input  logic              rx_trig,
  input  logic              rx_ready,
  input  logic              rx_timeout,
  input  logic              tx_empty,
  input  logic              tx_write,
  input  logic              modem_chg,
  output logic              irq,
  output logic [7:0]        ident
);
  import uart_irq_pkg::*;
  localparam int PAD = DATA_W - 8;

  logic [7:0]      en_q;
  logic            en_wr_hit;
  logic [NSRC-1:0] act;
  logic            tx_rise;
  logic            tx_ack;
  logic            unit_en;

  assign unit_en = en_q[UNIT_BIT];
  assign tx_ack  = bus_rd && (bus_addr == ID_ADDR) &&
                   (ident == pack_ident(1'b1, C_TX));

  uart_irq_enreg #(.ADDR_W(ADDR_W), .EN_ADDR(EN_ADDR)) u_en (
    .clk(clk), .rst_n(rst_n), .dlab(dlab), .addr(bus_addr),
    .wr(bus_wr), .wdata(bus_wdata), .en_q(en_q), .wr_hit(en_wr_hit)
  );

  uart_irq_srcs u_src (
    .clk(clk), .rst_n(rst_n), .en(en_q), .rx_err(rx_err),
    .fifo_mode(fifo_mode), .rx_trig(rx_trig), .rx_ready(rx_ready),
    .rx_timeout(rx_timeout), .tx_empty(tx_empty), .tx_write(tx_write),
    .modem_chg(modem_chg), .tx_ack(tx_ack), .act(act), .tx_rise(tx_rise)
  );

  uart_irq_arb u_arb (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .act(act),
    .irq(irq), .ident(ident)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == EN_ADDR && !dlab) bus_rdata = {{PAD{1'b0}}, en_q};
    else if (bus_addr == ID_ADDR)     bus_rdata = {{PAD{1'b0}}, ident};
  end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] EN_ADDR = 1,
  parameter logic [ADDR_W-1:0] ID_ADDR = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dlab,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              tx_write,
  input logic              irq,
  input logic [7:0]        ident,
  input logic [7:0]        en_q,
  input logic [4:0]        act,
  input logic              unit_en,
  input logic              tx_rise
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    irq == $past(unit_en && (act != 5'b0)));

  assert_unit_off_R3: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(!unit_en) |-> (!irq && ident == 8'h01));

  assert_line_status_top_R4: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(unit_en && act[0]) |-> (ident == 8'h06));

  assert_modem_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(unit_en && act == 5'b10000) |-> (ident == 8'h00));

  assert_pend_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq == !ident[0]) && (ident[7:4] == 4'h0));

  assert_dlab_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(bus_wr && bus_addr == EN_ADDR && dlab) |-> (en_q == $past(en_q)));

  assert_tx_ack_R9: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    $past(bus_rd && bus_addr == ID_ADDR && ident == 8'h02 && !tx_write && !tx_rise)
      |-> (ident != 8'h02));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.ADDR_W(ADDR_W), .EN_ADDR(EN_ADDR), .ID_ADDR(ID_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .dlab(dlab), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .tx_write(tx_write), .irq(irq), .ident(ident), .en_q(en_q),
  .act(act), .unit_en(unit_en), .tx_rise(tx_rise)
);

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dlab = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [31:0] bus_rdata;
  logic        rx_err = 1'b0, fifo_mode = 1'b0, rx_trig = 1'b0, rx_ready = 1'b0;
  logic        rx_timeout = 1'b0, tx_empty = 1'b0, tx_write = 1'b0, modem_chg = 1'b0;
  logic        irq;
  logic [7:0]  ident;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] en_s = 8'h00;
  bit         ack_s = 1'b0;

  typedef struct { logic irq; logic [7:0] id; string tag; } exp_t;
  exp_t q[$];
  event mon_ev;

  always #4 clk = ~clk;

  uart_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .dlab(dlab), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_err(rx_err),
    .fifo_mode(fifo_mode), .rx_trig(rx_trig), .rx_ready(rx_ready),
    .rx_timeout(rx_timeout), .tx_empty(tx_empty), .tx_write(tx_write),
    .modem_chg(modem_chg), .irq(irq), .ident(ident)
  );

  function automatic logic [7:0] model();
    if (!en_s[6])                                   return 8'h01;
    if (en_s[2] && rx_err)                          return 8'h06;
    if (en_s[0] && (fifo_mode ? rx_trig : rx_ready)) return 8'h04;
    if (en_s[4] && rx_timeout)                      return 8'h0C;
    if (en_s[1] && tx_empty && !ack_s)              return 8'h02;
    if (en_s[3] && modem_chg)                       return 8'h00;
    return 8'h01;
  endfunction

  // monitor: pops expected items and compares with the outputs
  initial forever begin
    exp_t e;
    @(mon_ev);
    #1;
    e = q.pop_front();
    n_cmp++;
    if (irq !== e.irq || ident !== e.id) begin
      n_bad++;
      $display("FAIL %s: irq=%b ident=%h expected irq=%b ident=%h", e.tag, irq, ident, e.irq, e.id);
    end
  end

  task automatic expect_now(string tag);
    exp_t e;
    logic [7:0] m;
    m = model();
    e.irq = !m[0];
    e.id = m;
    e.tag = tag;
    q.push_back(e);
    -> mon_ev;
    #2;
  endtask

  task automatic settle_check(string tag);
    repeat (2) @(negedge clk);
    expect_now(tag);
  endtask

  task automatic chk(string tag, logic [31:0] act_v, logic [31:0] exp_v);
    n_cmp++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act_v, exp_v);
    end
  endtask

  task automatic bus_write(logic [7:0] d);
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = d; bus_wr = 1'b1;
    if (!dlab) en_s = d & 8'h5F;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    if (a == 2'd2 && d == 32'h02) ack_s = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_tx(logic v);
    @(negedge clk);
    if (v && !tx_empty) ack_s = 1'b0;
    tx_empty = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_now("R1 reset outputs");
    rst_n = 1'b1;
    bus_read(2'd1, rd); chk("R1 enable reads 0", rd, 32'h0);
    bus_read(2'd2, rd); chk("R1 ident reads 01", rd, 32'h01);

    // R2 access and unused bits
    bus_write(8'hFF);
    bus_read(2'd1, rd); chk("R2 readback masks bits 5,7", rd, 32'h5F);
    settle_check("R11 all sources idle");
    dlab = 1'b1;
    bus_write(8'h00);
    bus_read(2'd1, rd); chk("R2 read blocked by dlab", rd, 32'h0);
    dlab = 1'b0;
    bus_read(2'd1, rd); chk("R2 write blocked by dlab", rd, 32'h5F);

    // R3 unit disabled
    bus_write(8'h1F);
    @(negedge clk); rx_err = 1'b1; rx_ready = 1'b1; modem_chg = 1'b1;
    settle_check("R3 unit off masks all");

    // R4 line status on top, R10 one-cycle latency
    bus_write(8'h5F);
    set_tx(1'b1);
    settle_check("R4 line status wins");
    @(negedge clk); rx_err = 1'b0;
    settle_check("R5 data available non-FIFO");
    @(negedge clk); rx_err = 1'b1; #1;
    chk("R10 irq not before edge", {31'b0, irq}, 32'h1);
    @(negedge clk); rx_err = 1'b0; rx_ready = 1'b0; modem_chg = 1'b0; tx_empty = 1'b0;
    bus_write(8'h5F);
    settle_check("R10 idle");
    @(negedge clk); modem_chg = 1'b1; #1;
    chk("R10 irq low before edge", {31'b0, irq}, 32'h0);
    @(negedge clk); #1;
    chk("R10 irq high one clock later", {31'b0, irq}, 32'h1);
    modem_chg = 1'b0;

    // R5 FIFO mode selection
    @(negedge clk); fifo_mode = 1'b1; rx_ready = 1'b1; rx_trig = 1'b0;
    settle_check("R5 FIFO mode ignores rx_ready");
    @(negedge clk); rx_trig = 1'b1; rx_ready = 1'b0;
    settle_check("R5 FIFO trigger level");

    // R6 timeout
    @(negedge clk); rx_timeout = 1'b1;
    settle_check("R6 data available over timeout");
    @(negedge clk); rx_trig = 1'b0;
    settle_check("R6 timeout code");
    set_tx(1'b1); modem_chg = 1'b1;
    bus_write(8'h4F);
    settle_check("R6 timeout enable cleared");
    bus_write(8'h5F);
    @(negedge clk); rx_timeout = 1'b0;
    settle_check("R7 transmit empty over modem");

    // R9 acknowledge and re-arm
    bus_read(2'd2, rd); chk("R9 ident shows transmit", rd, 32'h02);
    settle_check("R9 transmit cleared by read");
    @(negedge clk); tx_write = 1'b1; ack_s = 1'b0;
    @(negedge clk); tx_write = 1'b0;
    settle_check("R9 re-armed by write");
    bus_read(2'd2, rd); chk("R9 second read", rd, 32'h02);
    settle_check("R9 cleared again");
    set_tx(1'b0);
    set_tx(1'b1);
    settle_check("R9 re-armed by empty edge");

    // R8 modem lowest
    set_tx(1'b0);
    settle_check("R8 modem status");
    bus_write(8'h57);
    settle_check("R8 modem enable cleared");
    @(negedge clk); fifo_mode = 1'b0; rx_ready = 1'b1;
    bus_write(8'h5E);
    settle_check("R5 data enable cleared");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule